// File: doc/BRIEF.md
# Binary-Field Multiplicative Inverter (Itoh-Tsujii, Two Squarings per Clock)

This block returns the multiplicative inverse of an element of GF(2^M), by default M = 163 with the reduction polynomial x^163 + x^7 + x^6 + x^3 + 1. It raises the operand to the power 2^M - 2 with an Itoh-Tsujii addition chain. The chain is a sequence of squaring runs, each closed by one field multiplication. The chain comes from the binary expansion of M - 1. Each doubling step computes beta(2k) = beta(k)^(2^k) * beta(k). Each set bit then adds one step, beta(k+1) = beta(k)^2 * a. The chain ends with a single squaring. For M = 163 this takes 162 squarings and 9 multiplications.

Squaring runs use a stage that raises the working value to the fourth power in one clock, so two squarings finish per cycle. When a run has an odd length, its last squaring goes through a separate one-power path. Each squaring result is written back to the working register, and that register is the operand the multiplier takes in. The multiplier is a digit-serial most-significant-digit-first unit whose digit width is a parameter. Every square and every product is reduced back to M bits.

A caller presents an operand and pulses start while the block is idle. Some cycles later, done pulses for one cycle and the inverse appears on the result port. A zero operand has no inverse: it completes on the next clock with a zero result and the error flag set.

Top module: `gf2m_it_inverter`

## Requirements
- R1: For every nonzero operand a, the result r taken at the done pulse satisfies r * a = 1 in GF(2^M) modulo the configured polynomial (default x^163 + x^7 + x^6 + x^3 + 1; bit i of a port is the coefficient of x^i).
- R2: Each accepted start produces exactly one done pulse, and done is high for exactly one clock cycle.
- R3: A zero operand yields done on the clock after start is accepted, with result 0 and zero_err high.
- R4: A completion for a nonzero operand has zero_err low and a nonzero result.
- R5: A start pulse while an inversion is in progress is ignored. The operand is taken only in the cycle start is accepted, and later changes to it do not affect the running inversion.
- R6: result and zero_err hold their values from one done pulse until the next.
- R7: After reset, done, zero_err and result are all 0.
- R8: The inverse of the element 1 is exactly 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion; accepted only while idle |
| operand | input | M | Field element to invert, sampled when start is accepted |
| result | output | M | Inverse, valid from the done pulse and held afterwards |
| done | output | 1 | One-cycle completion pulse |
| zero_err | output | 1 | Set with done when the operand was zero, held with result |

## Verification
Every cycle, the assertions check the following. The done pulse lasts one cycle. A zero operand completes on the next clock with the error flag and a zero result. A nonzero operand never completes on the next clock and never returns zero. Result and flag stay unchanged between completions. The multiplier signals completion only while a run is active. The assertions cannot establish that the result is the inverse. The bench scenarios show that: they multiply each returned value by its operand and expect 1, over fixed edge elements and random ones. The bench scenarios also show that a start pulse and operand changes arriving mid-run leave the running inversion untouched.

// File: rtl/gf2m_inv_pkg.sv
package gf2m_inv_pkg;

   // Sequencer states of the inverter.
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SEG  = 3'd1,
      ST_SQR  = 3'd2,
      ST_MUL  = 3'd3,
      ST_FIN  = 3'd4
   } inv_state_e;

   // Default field: degree and low-order taps of the reduction polynomial.
   localparam int unsigned DEF_M = 163;
   localparam logic [DEF_M-1:0] DEF_TAPS = DEF_M'(8'hC9);

endpackage

// File: rtl/gf2m_sqr.sv
// Combinational squarer over GF(2^M), raising the input to 2^POWERS.
module gf2m_sqr #(
   parameter int unsigned M      = 163,
   parameter logic [M-1:0] TAPS  = M'(8'hC9),
   parameter int unsigned POWERS = 1
) (
   input  logic [M-1:0] din,
   output logic [M-1:0] dout
);

   localparam int unsigned WW = 2*M - 1;

   if (POWERS < 1 || POWERS > 2) begin : g_bad_powers
      $error("gf2m_sqr: POWERS must be 1 or 2");
   end

   function automatic logic [M-1:0] fold(input logic [WW-1:0] v_in);
      logic [WW-1:0] v;
      logic [WW-1:0] tx;
      v  = v_in;
      tx = WW'(TAPS);
      for (int i = WW - 1; i >= int'(M); i--) begin
         if (v[i]) begin
            v[i] = 1'b0;
            v    = v ^ (tx << (i - int'(M)));
         end
      end
      return v[M-1:0];
   endfunction

   function automatic logic [M-1:0] sq(input logic [M-1:0] x);
      logic [WW-1:0] w;
      w = '0;
      for (int i = 0; i < int'(M); i++) begin
         w[2*i] = x[i];
      end
      return fold(w);
   endfunction

   if (POWERS == 2) begin : g_quad
      logic [M-1:0] mid;
      assign mid  = sq(din);
      assign dout = sq(mid);
   end else begin : g_single
      assign dout = sq(din);
   end

endmodule

// File: rtl/gf2m_digit_mul.sv
// Digit-serial multiplier over GF(2^M), most significant digit of b first.
module gf2m_digit_mul #(
   parameter int unsigned M     = 163,
   parameter logic [M-1:0] TAPS = M'(8'hC9),
   parameter int unsigned DIGIT = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [M-1:0] a_in,
   input  logic [M-1:0] b_in,
   output logic [M-1:0] prod,
   output logic         fin
);

   localparam int unsigned NDIG = (M + DIGIT - 1) / DIGIT;
   localparam int unsigned PW   = NDIG * DIGIT;
   localparam int unsigned CW   = $clog2(NDIG + 1);

   if (DIGIT < 1 || DIGIT > M) begin : g_bad_digit
      $error("gf2m_digit_mul: DIGIT must lie in 1..M");
   end

   logic [M-1:0]  a_q;
   logic [PW-1:0] b_q;
   logic [M-1:0]  acc_q;
   logic [CW-1:0] left_q;
   logic          fin_q;

   function automatic logic [M-1:0] xtime(input logic [M-1:0] r);
      logic [M-1:0] s;
      s = r << 1;
      if (r[M-1]) s = s ^ TAPS;
      return s;
   endfunction

   function automatic logic [M-1:0] digit_step(input logic [M-1:0] r_in,
                                               input logic [M-1:0] a,
                                               input logic [DIGIT-1:0] dg);
      logic [M-1:0] r;
      r = r_in;
      for (int j = DIGIT - 1; j >= 0; j--) begin
         r = xtime(r);
         if (dg[j]) r = r ^ a;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         acc_q  <= '0;
         left_q <= '0;
         fin_q  <= 1'b0;
      end else if (go) begin
         a_q    <= a_in;
         b_q    <= PW'(b_in);
         acc_q  <= '0;
         left_q <= CW'(NDIG);
         fin_q  <= 1'b0;
      end else if (left_q != '0) begin
         acc_q  <= digit_step(acc_q, a_q, b_q[PW-1 -: DIGIT]);
         b_q    <= b_q << DIGIT;
         left_q <= left_q - 1'b1;
         fin_q  <= (left_q == CW'(1));
      end else begin
         fin_q  <= 1'b0;
      end
   end

   assign prod = acc_q;
   assign fin  = fin_q;

endmodule

// File: rtl/gf2m_it_inverter.sv
// Itoh-Tsujii inverter over GF(2^M) with a two-powers-per-clock squaring stage.
module gf2m_it_inverter
   import gf2m_inv_pkg::*;
#(
   parameter int unsigned M       = DEF_M,
   parameter logic [M-1:0] TAPS   = M'(DEF_TAPS),
   parameter int unsigned SQ_STEP = 2,
   parameter int unsigned DIGIT   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] operand,
   output logic [M-1:0] result,
   output logic         done,
   output logic         zero_err
);

   localparam int unsigned NB = $clog2(M);
   localparam int unsigned KW = NB + 1;
   localparam int unsigned BW = $clog2(NB + 1);
   localparam logic [KW-1:0] EXP = KW'(M - 1);
   localparam logic [KW-1:0] STEPV = KW'(SQ_STEP);

   if (M < 3) begin : g_bad_m
      $error("gf2m_it_inverter: M must be at least 3");
   end
   if (SQ_STEP < 1 || SQ_STEP > 2) begin : g_bad_step
      $error("gf2m_it_inverter: SQ_STEP must be 1 or 2");
   end

   inv_state_e   state_q;
   logic [M-1:0] acc_q;
   logic [M-1:0] base_q;
   logic [M-1:0] mop_q;
   logic [KW-1:0] k_q;
   logic [KW-1:0] sq_left_q;
   logic [BW-1:0] bits_left_q;
   logic          add_pend_q;
   logic [M-1:0] res_q;
   logic         done_q;
   logic         err_q;

   logic [M-1:0] one_out;
   logic [M-1:0] step_out;
   logic [M-1:0] acc_nxt;
   logic [KW-1:0] sq_left_nxt;
   logic         mul_go;
   logic [M-1:0] mul_prod;
   logic         mul_done;
   logic         run_q;
   logic [BW-1:0] bit_idx;

   // One-power path: odd tails of squaring runs and the closing square.
   gf2m_sqr #(.M(M), .TAPS(TAPS), .POWERS(1)) i_sq_one (
      .din  (acc_q),
      .dout (one_out)
   );

   if (SQ_STEP == 2) begin : g_quad_path
      gf2m_sqr #(.M(M), .TAPS(TAPS), .POWERS(2)) i_sq_quad (
         .din  (acc_q),
         .dout (step_out)
      );
   end else begin : g_single_path
      assign step_out = one_out;
   end

   always_comb begin
      if (sq_left_q >= STEPV) begin
         acc_nxt     = step_out;
         sq_left_nxt = sq_left_q - STEPV;
      end else begin
         acc_nxt     = one_out;
         sq_left_nxt = sq_left_q - KW'(1);
      end
   end

   assign mul_go  = (state_q == ST_SQR) && (sq_left_nxt == '0);
   assign bit_idx = bits_left_q - BW'(1);
   assign run_q   = (state_q != ST_IDLE);

   // The multiplier takes the squaring result as it is written back.
   gf2m_digit_mul #(.M(M), .TAPS(TAPS), .DIGIT(DIGIT)) i_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mul_go),
      .a_in  (acc_nxt),
      .b_in  (mop_q),
      .prod  (mul_prod),
      .fin   (mul_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         acc_q       <= '0;
         base_q      <= '0;
         mop_q       <= '0;
         k_q         <= '0;
         sq_left_q   <= '0;
         bits_left_q <= '0;
         add_pend_q  <= 1'b0;
         res_q       <= '0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (operand == '0) begin
                     res_q  <= '0;
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else begin
                     acc_q       <= operand;
                     base_q      <= operand;
                     k_q         <= KW'(1);
                     bits_left_q <= BW'(NB - 1);
                     add_pend_q  <= 1'b0;
                     state_q     <= ST_SEG;
                  end
               end
            end
            ST_SEG: begin
               if (add_pend_q) begin
                  sq_left_q  <= KW'(1);
                  mop_q      <= base_q;
                  k_q        <= k_q + KW'(1);
                  add_pend_q <= 1'b0;
                  state_q    <= ST_SQR;
               end else if (bits_left_q != '0) begin
                  sq_left_q   <= k_q;
                  mop_q       <= acc_q;
                  k_q         <= k_q << 1;
                  add_pend_q  <= EXP[bit_idx];
                  bits_left_q <= bit_idx;
                  state_q     <= ST_SQR;
               end else begin
                  state_q <= ST_FIN;
               end
            end
            ST_SQR: begin
               acc_q     <= acc_nxt;
               sq_left_q <= sq_left_nxt;
               if (sq_left_nxt == '0) state_q <= ST_MUL;
            end
            ST_MUL: begin
               if (mul_done) begin
                  acc_q   <= mul_prod;
                  state_q <= ST_SEG;
               end
            end
            ST_FIN: begin
               res_q   <= one_out;
               err_q   <= 1'b0;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign result   = res_q;
   assign done     = done_q;
   assign zero_err = err_q;

endmodule

// File: rtl/gf2m_it_inverter_chk.sv
// Property checker attached to the inverter.
module gf2m_it_inverter_chk #(
   parameter int unsigned M = 163
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [M-1:0] operand,
   input logic [M-1:0] result,
   input logic         done,
   input logic         zero_err,
   input logic         run_q,
   input logic         mul_done
);

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_zero_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !run_q && operand == '0) |=> (done && zero_err && result == '0));

   assert_zero_flag_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zero_err) |-> (result == '0));

   assert_nonzero_not_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !run_q && operand != '0) |=> !done);

   assert_nonzero_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !zero_err) |-> (result != '0));

   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(zero_err)));

   assert_mul_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mul_done |-> run_q);

endmodule

bind gf2m_it_inverter gf2m_it_inverter_chk #(.M(M)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .operand  (operand),
   .result   (result),
   .done     (done),
   .zero_err (zero_err),
   .run_q    (run_q),
   .mul_done (mul_done)
);

// File: tb/test_gf2m_it_inverter.sv
module test_gf2m_it_inverter;

   localparam int unsigned M = 163;
   localparam logic [M-1:0] TAPS = M'(8'hC9);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [M-1:0] operand = '0;
   logic [M-1:0] result;
   logic         done;
   logic         zero_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [M-1:0] exp_q[$];
   logic         prev_done = 1'b0;

   always #10 clk = ~clk;

   gf2m_it_inverter #(.M(M), .TAPS(TAPS)) i_gf2m_it_inverter (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .operand  (operand),
      .result   (result),
      .done     (done),
      .zero_err (zero_err)
   );

   // Bench model: LSB-first shift-and-add product.
   function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a_in,
                                            input logic [M-1:0] b);
      logic [M-1:0] a;
      logic [M-1:0] r;
      a = a_in;
      r = '0;
      for (int i = 0; i < int'(M); i++) begin
         if (b[i]) r = r ^ a;
         if (a[M-1]) a = (a << 1) ^ TAPS;
         else        a = a << 1;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [M-1:0] act, input logic [M-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops the expected operand at each completion.
   always @(negedge clk) begin
      if (rst_n && done) begin
         check(!prev_done, "R2 done width", M'(prev_done), '0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected done", result, '0);
         end else begin
            logic [M-1:0] op;
            op = exp_q.pop_front();
            if (op == '0) begin
               check(result == '0, "R3 zero result", result, '0);
               check(zero_err, "R3 zero flag", M'(zero_err), M'(1));
            end else begin
               check(ref_mul(result, op) == M'(1), "R1 product",
                     ref_mul(result, op), M'(1));
               check(!zero_err && result != '0, "R4 flag clear",
                     M'(zero_err), '0);
               if (op == M'(1))
                  check(result == M'(1), "R8 inverse of one", result, M'(1));
            end
         end
      end
      prev_done <= done;
   end

   task automatic drive(input logic [M-1:0] x);
      exp_q.push_back(x);
      @(negedge clk);
      operand = x;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      operand = '0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [M-1:0] rnd_elem();
      logic [M-1:0] v;
      v = M'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
      if (v == '0) v = M'(1);
      return v;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      check(done == 1'b0, "R7 done", M'(done), '0);
      check(zero_err == 1'b0, "R7 zero_err", M'(zero_err), '0);
      check(result == '0, "R7 result", result, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      drive(M'(1));
      drive(M'(2));
      drive({M{1'b1}});
      drive(M'(1) << (M - 1));
      drive(TAPS);
      drive('0);
      drive(M'(3));
      for (int i = 0; i < 8; i++) drive(rnd_elem());

      // R5: second start and operand change mid-run are ignored.
      begin
         logic [M-1:0] first;
         first = rnd_elem();
         exp_q.push_back(first);
         @(negedge clk);
         operand = first;
         start   = 1'b1;
         @(negedge clk);
         start   = 1'b0;
         operand = rnd_elem();
         repeat (5) @(negedge clk);
         start   = 1'b1;
         @(negedge clk);
         start   = 1'b0;
         while (exp_q.size() != 0) @(negedge clk);
         repeat (600) @(negedge clk);
         check(exp_q.size() == 0 && done == 1'b0, "R5 no extra run",
               M'(done), '0);
      end

      // R6: result held between completions.
      begin
         logic [M-1:0] held;
         logic [M-1:0] x;
         x = rnd_elem();
         drive(x);
         held = result;
         operand = rnd_elem();
         repeat (40) @(negedge clk);
         check(result == held, "R6 result hold", result, held);
         check(zero_err == 1'b0, "R6 flag hold", M'(zero_err), '0);
         check(ref_mul(held, x) == M'(1), "R6 held value", ref_mul(held, x), M'(1));
         operand = '0;
      end

      drive('0);
      drive(rnd_elem());

      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", '0, '0);
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule